// File: doc/BRIEF.md
# SECDED-Protected SRAM Access Controller

This controller connects one valid/ready request port to a 32-bit on-chip SRAM. Each data word is kept in the array together with seven check bits, forming a 39-bit extended Hamming codeword. Reads return corrected data one cycle after acceptance. A correctable (single-bit) error is flagged for that response, and an uncorrectable (double-bit) error is flagged as well.

Every write is posted into a one-deep write-back stage. The stage reads the stored codeword, corrects it, merges the enabled byte lanes of the new data, re-encodes the word and writes it back one cycle after acceptance. Full-word writes and sub-word writes therefore use the same path. The requester never sees check bits. A sub-word write stalls for exactly one cycle only when the request accepted in the previous cycle was a read, because the array output is still committed to that read's response. Every other access is accepted without a wait state.

The array is a simple synchronous model with a registered read address. An error-injection mask is XORed into the codeword of every write, so that test stimulus can plant single-bit and double-bit faults.

Top module: `ecc_sram_ctrl`

## Requirements
- R1: While reset is held and in the first cycle after it, `req_ready` is 1 and `rsp_valid`, `rsp_ce` and `rsp_ue` are 0.
- R2: A read is accepted in the cycle it is presented, with no wait state. `rsp_valid` is 1 in the next cycle, and `rsp_rdata` then carries the stored word.
- R3: A write with `req_be` = 4'hF is accepted with no wait state, whatever request came before it. A later read returns `req_wdata`.
- R4: A write with any other `req_be` replaces only the byte lanes whose enable bit is set (bit i selects data bits 8i+7..8i) and keeps the other lanes of the stored word.
- R5: A sub-word write presented in the cycle right after an accepted read sees `req_ready` low for exactly one cycle. Presented after a write or after an idle cycle, it is accepted at once.
- R6: A stored word with one flipped codeword bit reads back corrected, with `rsp_ce` = 1 and `rsp_ue` = 0 in the response cycle.
- R7: A stored word with two flipped codeword bits reads back with `rsp_ue` = 1 and `rsp_ce` = 0.
- R8: A sub-word write whose old word is uncorrectable is dropped: its response has `rsp_ue` = 1, and the stored word keeps its fault.
- R9: A sub-word write whose old word has a single-bit error responds with `rsp_ce` = 1 and stores the corrected, merged word, which then reads back clean.
- R10: `inj_mask` is XORed into the 39-bit codeword written for the request it accompanies. Bit 0 is the overall parity. Bits 1, 2, 4, 8, 16 and 32 are Hamming check bits. Data bits 0..31 fill the remaining positions 3..38 in ascending order. Any one set mask bit, including bit 0 and bit 38, yields a correctable word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted at this edge when valid |
| req_we | input | 1 | 1 = write, 0 = read |
| req_be | input | 4 | Byte-lane enables for writes |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | 32 | Write data |
| inj_mask | input | 39 | Codeword bits to flip on the accompanying write |
| rsp_valid | output | 1 | Response for the request accepted in the previous cycle |
| rsp_rdata | output | 32 | Corrected read data (0 for writes) |
| rsp_ce | output | 1 | Single-bit error corrected |
| rsp_ue | output | 1 | Uncorrectable error seen |

## Verification
The assertions assume that a requester keeps `req_valid` and its fields steady while `req_ready` is low. They also assume that a read never targets a word that has not been written, since the array is not initialised. The stimulus table is issued back to back by one task that holds every field until acceptance. Every address is written with a full word before it is read or partially written. `inj_mask` is nonzero only on the full-word writes that plant faults.

// File: rtl/secded32_pkg.sv
package secded32_pkg;
  localparam int DATA_W = 32;
  localparam int CODE_W = 39;
  localparam int CHK_W  = 6;

  typedef struct packed {
    logic [DATA_W-1:0] data;
    logic              ce;
    logic              ue;
  } dec_t;

  // Position p (1..38) holds a Hamming check bit when p is a power of two.
  function automatic bit is_chk_pos(input int p);
    return (p & (p - 1)) == 0;
  endfunction

  function automatic logic [CODE_W-1:0] secded_encode(input logic [DATA_W-1:0] d);
    logic [CODE_W-1:0] c;
    logic [4:0]        k;
    logic              x;
    c = '0;
    k = '0;
    for (int p = 1; p < CODE_W; p++) begin
      if (!is_chk_pos(p)) begin
        c[p] = d[k];
        k    = k + 5'd1;
      end
    end
    for (int b = 0; b < CHK_W; b++) begin
      x = 1'b0;
      for (int p = 1; p < CODE_W; p++) if (p[b]) x = x ^ c[p];
      c[1 << b] = x;
    end
    c[0] = ^c[CODE_W-1:1];
    return c;
  endfunction

  function automatic dec_t secded_decode(input logic [CODE_W-1:0] cw);
    logic [CODE_W-1:0] c;
    logic [CHK_W-1:0]  s;
    logic              par;
    logic [4:0]        k;
    dec_t              r;
    c   = cw;
    s   = '0;
    par = ^cw;
    r   = '0;
    for (int b = 0; b < CHK_W; b++)
      for (int p = 1; p < CODE_W; p++) if (p[b]) s[b] = s[b] ^ cw[p];
    if (par) begin
      if (s == '0) begin
        r.ce = 1'b1;
      end else if (s < 6'd39) begin
        c[s] = ~c[s];
        r.ce = 1'b1;
      end else begin
        r.ue = 1'b1;
      end
    end else if (s != '0) begin
      r.ue = 1'b1;
    end
    k = '0;
    for (int p = 1; p < CODE_W; p++) begin
      if (!is_chk_pos(p)) begin
        r.data[k] = c[p];
        k         = k + 5'd1;
      end
    end
    return r;
  endfunction
endpackage

// File: rtl/sram_sync_array.sv
module sram_sync_array #(
  parameter int ADDR_W = 8,
  parameter int WIDTH  = 39
) (
  input  logic              clk,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [WIDTH-1:0]  rd_data,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [WIDTH-1:0]  wr_data
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [WIDTH-1:0]  mem [DEPTH];
  logic [ADDR_W-1:0] rd_addr_q;

  always_ff @(posedge clk) begin
    if (rd_en) rd_addr_q <= rd_addr;
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  // Registered address: a write at edge t is visible to a read registered at t.
  assign rd_data = mem[rd_addr_q];
endmodule

// File: rtl/secded_rmw.sv
module secded_rmw
  import secded32_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic [CODE_W-1:0] old_cw,
  input  logic [LANES-1:0]  lane_en,
  input  logic [DATA_W-1:0] new_data,
  output logic [DATA_W-1:0] old_data,
  output logic              old_ce,
  output logic              old_ue,
  output logic [CODE_W-1:0] merged_cw
);
  localparam int LANE_W = DATA_W / LANES;

  dec_t              dec;
  logic [DATA_W-1:0] merged;

  assign dec      = secded_decode(old_cw);
  assign old_data = dec.data;
  assign old_ce   = dec.ce;
  assign old_ue   = dec.ue;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign merged[g*LANE_W +: LANE_W] = lane_en[g] ? new_data[g*LANE_W +: LANE_W]
                                                   : dec.data[g*LANE_W +: LANE_W];
  end

  assign merged_cw = secded_encode(merged);
endmodule

// File: rtl/ecc_sram_ctrl.sv
module ecc_sram_ctrl
  import secded32_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_we,
  input  logic [3:0]        req_be,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  input  logic [38:0]       inj_mask,
  output logic              rsp_valid,
  output logic [31:0]       rsp_rdata,
  output logic              rsp_ce,
  output logic              rsp_ue
);
  localparam int LANES = DATA_W / 8;
  localparam logic [LANES-1:0] ALL_LANES = '1;

  logic              acc, req_sub, prev_rd;
  logic              s2_valid, s2_we, s2_sub;
  logic [LANES-1:0]  s2_be;
  logic [ADDR_W-1:0] s2_addr;
  logic [DATA_W-1:0] s2_wdata;
  logic [CODE_W-1:0] s2_mask;
  logic [CODE_W-1:0] arr_rd, wb_cw;
  logic [DATA_W-1:0] old_data;
  logic              old_ce, old_ue;
  logic              wb_drop, mem_we, flag_ok;

  assign req_sub   = req_we && (req_be != ALL_LANES);
  assign req_ready = !(req_sub && prev_rd);
  assign acc       = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_rd  <= 1'b0;
      s2_valid <= 1'b0;
      s2_we    <= 1'b0;
      s2_sub   <= 1'b0;
      s2_be    <= '0;
      s2_addr  <= '0;
      s2_wdata <= '0;
      s2_mask  <= '0;
    end else begin
      prev_rd  <= acc && !req_we;
      s2_valid <= acc;
      if (acc) begin
        s2_we    <= req_we;
        s2_sub   <= req_sub;
        s2_be    <= req_be;
        s2_addr  <= req_addr;
        s2_wdata <= req_wdata;
        s2_mask  <= inj_mask;
      end
    end
  end

  sram_sync_array #(.ADDR_W(ADDR_W), .WIDTH(CODE_W)) u_arr (
    .clk     (clk),
    .rd_en   (acc),
    .rd_addr (req_addr),
    .rd_data (arr_rd),
    .wr_en   (mem_we),
    .wr_addr (s2_addr),
    .wr_data (wb_cw ^ s2_mask)
  );

  secded_rmw #(.LANES(LANES)) u_rmw (
    .old_cw    (arr_rd),
    .lane_en   (s2_be),
    .new_data  (s2_wdata),
    .old_data  (old_data),
    .old_ce    (old_ce),
    .old_ue    (old_ue),
    .merged_cw (wb_cw)
  );

  assign wb_drop   = s2_valid && s2_sub && old_ue;
  assign mem_we    = s2_valid && s2_we && !wb_drop;
  assign flag_ok   = s2_valid && (!s2_we || s2_sub);
  assign rsp_valid = s2_valid;
  assign rsp_rdata = (s2_valid && !s2_we) ? old_data : '0;
  assign rsp_ce    = flag_ok && old_ce;
  assign rsp_ue    = flag_ok && old_ue;

  a_r2_read_no_wait: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_we) |-> req_ready);
  a_r2_rsp_next_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> rsp_valid);
  a_r3_full_write_no_wait: assert property (@(posedge clk) disable iff (!rst_n)
    (req_we && req_be == ALL_LANES) |-> req_ready);
  a_r5_single_wait: assert property (@(posedge clk) disable iff (!rst_n)
    !req_ready |=> req_ready);
  a_r5_wait_only_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    !req_ready |-> $past(acc && !req_we));
  a_r7_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(rsp_ce && rsp_ue));
  a_r6_flag_with_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_ce || rsp_ue) |-> rsp_valid);
  a_r8_drop_reports_ue: assert property (@(posedge clk) disable iff (!rst_n)
    wb_drop |-> (rsp_ue && !mem_we));
endmodule

// File: tb/ecc_sram_ctrl_tb.sv
`timescale 1ns/100ps
module ecc_sram_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_we = 1'b0;
  logic [3:0]  req_be = 4'h0;
  logic [7:0]  req_addr = 8'h0;
  logic [31:0] req_wdata = 32'h0;
  logic [38:0] inj_mask = 39'h0;
  logic        req_ready, rsp_valid, rsp_ce, rsp_ue;
  logic [31:0] rsp_rdata;
  int          n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;

  ecc_sram_ctrl #(.ADDR_W(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_we(req_we), .req_be(req_be), .req_addr(req_addr), .req_wdata(req_wdata),
    .inj_mask(inj_mask), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .rsp_ce(rsp_ce), .rsp_ue(rsp_ue)
  );

  typedef struct packed {
    logic        we;
    logic [3:0]  be;
    logic [7:0]  addr;
    logic [31:0] wdata;
    logic [38:0] mask;
    logic        chkd;
    logic [31:0] exp;
    logic        ce;
    logic        ue;
    logic [1:0]  waits;
  } vec_t;

  localparam vec_t VEC [20] = '{
    '{1'b1, 4'hF, 8'h01, 32'h11223344, 39'h0,  1'b0, 32'h0,        1'b0, 1'b0, 2'd0}, // R3
    '{1'b0, 4'h0, 8'h01, 32'h0,        39'h0,  1'b1, 32'h11223344, 1'b0, 1'b0, 2'd0}, // R2
    '{1'b1, 4'h1, 8'h01, 32'h000000AA, 39'h0,  1'b0, 32'h0,        1'b0, 1'b0, 2'd1}, // R5 after read
    '{1'b0, 4'h0, 8'h01, 32'h0,        39'h0,  1'b1, 32'h112233AA, 1'b0, 1'b0, 2'd0}, // R4
    '{1'b1, 4'hC, 8'h01, 32'hBEEF0000, 39'h0,  1'b0, 32'h0,        1'b0, 1'b0, 2'd1}, // R5
    '{1'b1, 4'h2, 8'h01, 32'h00005500, 39'h0,  1'b0, 32'h0,        1'b0, 1'b0, 2'd0}, // R5 after write
    '{1'b0, 4'h0, 8'h01, 32'h0,        39'h0,  1'b1, 32'hBEEF55AA, 1'b0, 1'b0, 2'd0}, // R4
    '{1'b1, 4'hF, 8'h02, 32'hCAFEF00D, 39'h20, 1'b0, 32'h0,        1'b0, 1'b0, 2'd0}, // R10
    '{1'b0, 4'h0, 8'h02, 32'h0,        39'h0,  1'b1, 32'hCAFEF00D, 1'b1, 1'b0, 2'd0}, // R6
    '{1'b1, 4'hF, 8'h03, 32'h0F0F0F0F, 39'h208,1'b0, 32'h0,        1'b0, 1'b0, 2'd0}, // R10
    '{1'b0, 4'h0, 8'h03, 32'h0,        39'h0,  1'b0, 32'h0,        1'b0, 1'b1, 2'd0}, // R7
    '{1'b1, 4'h1, 8'h03, 32'h00000077, 39'h0,  1'b0, 32'h0,        1'b0, 1'b1, 2'd1}, // R8
    '{1'b1, 4'hF, 8'h04, 32'h12345678, 39'h1,  1'b0, 32'h0,        1'b0, 1'b0, 2'd0}, // R3 after sub-word
    '{1'b1, 4'h4, 8'h04, 32'h00990000, 39'h0,  1'b0, 32'h0,        1'b1, 1'b0, 2'd0}, // R9
    '{1'b0, 4'h0, 8'h04, 32'h0,        39'h0,  1'b1, 32'h12995678, 1'b0, 1'b0, 2'd0}, // R9
    '{1'b0, 4'h0, 8'h03, 32'h0,        39'h0,  1'b0, 32'h0,        1'b0, 1'b1, 2'd0}, // R8 kept
    '{1'b1, 4'h3, 8'h02, 32'h0000BEEF, 39'h0,  1'b0, 32'h0,        1'b1, 1'b0, 2'd1}, // R9
    '{1'b0, 4'h0, 8'h02, 32'h0,        39'h0,  1'b1, 32'hCAFEBEEF, 1'b0, 1'b0, 2'd0}, // R9
    '{1'b1, 4'hF, 8'h05, 32'hFFFFFFFF, 39'h40_0000_0000, 1'b0, 32'h0, 1'b0, 1'b0, 2'd0}, // R3
    '{1'b0, 4'h0, 8'h05, 32'h0,        39'h0,  1'b1, 32'hFFFFFFFF, 1'b1, 1'b0, 2'd0}  // R10 top bit
  };

  task automatic check(input string req, input logic [38:0] act, input logic [38:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Drive at a falling edge, hold until accepted, sample the response one cycle later.
  task automatic run(input logic we, input logic [3:0] be, input logic [7:0] a,
                     input logic [31:0] d, input logic [38:0] m, output int waits,
                     output logic [31:0] rd, output logic v, output logic ce, output logic ue);
    req_valid = 1'b1; req_we = we; req_be = be; req_addr = a; req_wdata = d; inj_mask = m;
    waits = 0;
    #0.5;
    while (!req_ready) begin
      waits++;
      @(negedge clk);
      #0.5;
    end
    @(negedge clk);
    rd = rsp_rdata; v = rsp_valid; ce = rsp_ce; ue = rsp_ue;
  endtask

  task automatic idle();
    req_valid = 1'b0; inj_mask = '0;
    @(negedge clk);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int          w;
    logic [31:0] rd;
    logic        v, ce, ue;
    repeat (3) @(negedge clk);
    check("R1 ready in reset", {38'h0, req_ready}, 39'h1);
    check("R1 rsp_valid in reset", {38'h0, rsp_valid}, 39'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 ready after reset", {38'h0, req_ready}, 39'h1);
    check("R1 flags after reset", {37'h0, rsp_ce, rsp_ue}, 39'h0);
    check("R1 rsp_valid after reset", {38'h0, rsp_valid}, 39'h0);

    for (int i = 0; i < 20; i++) begin
      run(VEC[i].we, VEC[i].be, VEC[i].addr, VEC[i].wdata, VEC[i].mask, w, rd, v, ce, ue);
      check($sformatf("R5 waits vec %0d", i), 39'(w), 39'(VEC[i].waits));
      check($sformatf("R2 rsp_valid vec %0d", i), {38'h0, v}, 39'h1);
      check($sformatf("R6 ce vec %0d", i), {38'h0, ce}, {38'h0, VEC[i].ce});
      check($sformatf("R7 ue vec %0d", i), {38'h0, ue}, {38'h0, VEC[i].ue});
      if (VEC[i].chkd)
        check($sformatf("R4 data vec %0d", i), {7'h0, rd}, {7'h0, VEC[i].exp});
    end
    idle();
    check("R2 rsp_valid drops when idle", {38'h0, rsp_valid}, 39'h0);

    // R5: a read, an idle cycle, then a sub-word write: no wait.
    run(1'b0, 4'h0, 8'h01, 32'h0, 39'h0, w, rd, v, ce, ue);
    idle();
    run(1'b1, 4'h8, 8'h01, 32'hAA000000, 39'h0, w, rd, v, ce, ue);
    check("R5 sub-word write after idle gap", 39'(w), 39'd0);
    run(1'b0, 4'h0, 8'h01, 32'h0, 39'h0, w, rd, v, ce, ue);
    check("R4 top lane merged", {7'h0, rd}, {7'h0, 32'hAAEF55AA});
    // R3: full write right after a read, then overwritten value read back.
    run(1'b1, 4'hF, 8'h01, 32'h5A5A0001, 39'h0, w, rd, v, ce, ue);
    check("R3 full write after read no wait", 39'(w), 39'd0);
    run(1'b0, 4'h0, 8'h01, 32'h0, 39'h0, w, rd, v, ce, ue);
    check("R3 full write readback", {7'h0, rd}, {7'h0, 32'h5A5A0001});
    check("R6 clean word no ce", {37'h0, ce, ue}, 39'h0);
    idle();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule